// File: doc/BRIEF.md
# Link-Register Branch Unit

This unit resolves branch-and-link instructions for a processor core that keeps its return address in register 0 instead of on a stack. It runs in the last pipeline stage. Each accepted branch produces a redirect target for the program counter. It also produces a register-file write of a packed link word that carries the zero flag, the carry flag and the return address.

Two branch forms are handled. The plain link form jumps to an operand that the decoder has already resolved; that operand is either an absolute value or a displacement from the program counter. The table form adds a 9-bit immediate offset to an index register value. In relative mode the program counter is also added. In absolute mode the program counter is left out and the offset is scaled by four.

A prefix instruction can supply the upper offset bits for the next instruction. The unit also tells the forwarding network when a younger instruction reads register 0 while a link write is in flight.

Top module: `lnk_branch_unit`

## Requirements
- R1: The write data is {Z at bit 31, C at bit 30, zeros in bits 29..16, return address in bits 15..0}. The return address is the branch instruction's PC plus one, wrapping modulo 2^16.
- R2: Every branch raises the write enable together with the branch-valid output, and the write address is always 0.
- R3: For op code 1 (link), the target is the operand when the relative bit is 0. It is PC + operand when the relative bit is 1. Both are taken modulo 2^16.
- R4: For op code 2 (table) with the absolute bit at 0, the target is PC + offset + index value, modulo 2^16.
- R5: For op code 2 with the absolute bit at 1, the target is index value + (offset << 2), modulo 2^16.
- R6: After an op code 3 (prefix) instruction, the offset becomes {prefix value, 9-bit immediate}. Without a prefix, the offset is the 9-bit immediate, zero-extended.
- R7: The next non-bubble instruction consumes a held prefix, whatever kind of instruction it is. Bubbles (op code 0) leave the prefix held. A prefix never affects a link target.
- R8: The forced-destination flag is 1 with a branch result exactly when the instruction's encoded destination field was non-zero.
- R9: The forward-hit output is 1 exactly when a link write is present and the younger instruction's valid read address is 0.
- R10: Results appear one clock after the instruction is presented. Bubbles and prefixes produce no branch and no write. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | 0 bubble, 1 link, 2 table, 3 prefix |
| tab_abs_i | input | 1 | Table form: 1 selects the absolute mode |
| link_rel_i | input | 1 | Link form: 1 adds the PC to the operand |
| pc_i | input | 16 | Address of the presented instruction |
| opnd_i | input | 32 | Resolved link operand |
| dval_i | input | 32 | Index register value |
| s_imm_i | input | 9 | Immediate offset field |
| aug_val_i | input | 23 | Upper offset bits carried by a prefix |
| z_i | input | 1 | Zero flag |
| c_i | input | 1 | Carry flag |
| dst_i | input | 9 | Encoded destination field |
| rd_valid_i | input | 1 | Younger instruction reads a register |
| rd_addr_i | input | 9 | Younger instruction's read address |
| br_valid_o | output | 1 | Branch result present |
| next_pc_o | output | 16 | Branch target |
| wr_en_o | output | 1 | Register write request |
| wr_addr_o | output | 9 | Write address (always 0) |
| wr_data_o | output | 32 | Packed link word |
| force0_o | output | 1 | Destination was redirected to 0 |
| fwd_hit_o | output | 1 | Younger read of register 0 must take the link word |

## Verification
The forwarding check and a new branch can fall in the same cycle. The bench raises a register-0 read during the cycle in which the next branch is being presented. It then judges that the hit reflects the older link word, while the new branch result only appears one edge later. Prefix consumption and a table branch also coincide. A prefix is followed by a bubble and then a table branch, and the target must include the upper bits exactly once. The table branch after it must not include them.

// File: rtl/lnk_pkg.sv
// Shared definitions for the link-register branch unit.
// Assumes a two-bit operation code supplied by the decoder.
package lnk_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LINK  = 2'd1,
        OP_TABLE = 2'd2,
        OP_AUG   = 2'd3
    } lnk_op_e;
endpackage

// File: rtl/lnk_aug_hold.sv
// Holds the upper offset bits delivered by a prefix instruction.
// Assumes bubbles are marked with OP_NONE; any other op consumes the prefix.
module lnk_aug_hold #(
    parameter int HI_W = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lnk_pkg::lnk_op_e op,
    input  logic [HI_W-1:0] aug_val,
    output logic [HI_W-1:0] hi,
    output logic            held
);
    // Load on prefix, clear on any other real instruction, keep on bubbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi   <= '0;
            held <= 1'b0;
        end else if (op == lnk_pkg::OP_AUG) begin
            hi   <= aug_val;
            held <= 1'b1;
        end else if (op != lnk_pkg::OP_NONE) begin
            hi   <= '0;
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/lnk_target_calc.sv
// Combinational branch-target adder for the link and table forms.
// Assumes PC_W <= DATA_W; all sums wrap to PC_W bits.
module lnk_target_calc #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 16,
    parameter int IMM_W  = 9
) (
    input  lnk_pkg::lnk_op_e         op,
    input  logic                     tab_abs,
    input  logic                     link_rel,
    input  logic [PC_W-1:0]          pc,
    input  logic [DATA_W-1:0]        opnd,
    input  logic [DATA_W-1:0]        dval,
    input  logic [IMM_W-1:0]         s_imm,
    input  logic [DATA_W-IMM_W-1:0]  aug_hi,
    input  logic                     aug_held,
    output logic [PC_W-1:0]          target
);
    localparam int HI_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] pc_ext;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] sum;

    // Widen the PC for the data-width adders.
    generate
        if (PC_W < DATA_W) begin : g_pad
            assign pc_ext = {{(DATA_W-PC_W){1'b0}}, pc};
        end else begin : g_nopad
            assign pc_ext = pc;
        end
    endgenerate

    // Build the offset from the immediate and a held prefix, if any.
    always_comb begin
        offset = aug_held ? {aug_hi, s_imm} : {{HI_W{1'b0}}, s_imm};
    end

    // Pick the adder terms for the active form.
    always_comb begin
        sum = '0;
        if (op == lnk_pkg::OP_LINK) begin
            sum = link_rel ? (pc_ext + opnd) : opnd;
        end else if (op == lnk_pkg::OP_TABLE) begin
            sum = tab_abs ? (dval + (offset << 2)) : (pc_ext + offset + dval);
        end
        target = sum[PC_W-1:0];
    end
endmodule

// File: rtl/lnk_word_pack.sv
// Packs the flags and return address into the link word.
// Assumes DATA_W >= PC_W + 2; the middle bits are zero.
module lnk_word_pack #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 16
) (
    input  logic              z,
    input  logic              c,
    input  logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - 2 - PC_W;

    logic [PC_W-1:0] ret_pc;

    // Return to the instruction after the branch.
    always_comb ret_pc = pc + PC_W'(1);

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {z, c, {PAD_W{1'b0}}, ret_pc};
        end else begin : g_nopad
            assign word = {z, c, ret_pc};
        end
    endgenerate
endmodule

// File: rtl/lnk_branch_unit.sv
// Last-stage branch-and-link unit: registers the target and the write of
// the link word to register 0, and flags forwarding of that write.
// Assumes the decoder has resolved the link operand and classified the op.
module lnk_branch_unit #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 16,
    parameter int IMM_W  = 9,
    parameter int RA_W   = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              op_i,
    input  logic                    tab_abs_i,
    input  logic                    link_rel_i,
    input  logic [PC_W-1:0]         pc_i,
    input  logic [DATA_W-1:0]       opnd_i,
    input  logic [DATA_W-1:0]       dval_i,
    input  logic [IMM_W-1:0]        s_imm_i,
    input  logic [DATA_W-IMM_W-1:0] aug_val_i,
    input  logic                    z_i,
    input  logic                    c_i,
    input  logic [RA_W-1:0]         dst_i,
    input  logic                    rd_valid_i,
    input  logic [RA_W-1:0]         rd_addr_i,
    output logic                    br_valid_o,
    output logic [PC_W-1:0]         next_pc_o,
    output logic                    wr_en_o,
    output logic [RA_W-1:0]         wr_addr_o,
    output logic [DATA_W-1:0]       wr_data_o,
    output logic                    force0_o,
    output logic                    fwd_hit_o
);
    import lnk_pkg::*;

    localparam int HI_W = DATA_W - IMM_W;

    lnk_op_e           op;
    logic              is_branch;
    logic [HI_W-1:0]   aug_hi;
    logic              aug_held;
    logic [PC_W-1:0]   target;
    logic [DATA_W-1:0] link_word;

    // Decode the incoming operation class.
    always_comb begin
        op        = lnk_op_e'(op_i);
        is_branch = (op == OP_LINK) || (op == OP_TABLE);
    end

    lnk_aug_hold #(.HI_W(HI_W)) u_aug (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .aug_val (aug_val_i),
        .hi      (aug_hi),
        .held    (aug_held)
    );

    lnk_target_calc #(.DATA_W(DATA_W), .PC_W(PC_W), .IMM_W(IMM_W)) u_tgt (
        .op       (op),
        .tab_abs  (tab_abs_i),
        .link_rel (link_rel_i),
        .pc       (pc_i),
        .opnd     (opnd_i),
        .dval     (dval_i),
        .s_imm    (s_imm_i),
        .aug_hi   (aug_hi),
        .aug_held (aug_held),
        .target   (target)
    );

    lnk_word_pack #(.DATA_W(DATA_W), .PC_W(PC_W)) u_pack (
        .z    (z_i),
        .c    (c_i),
        .pc   (pc_i),
        .word (link_word)
    );

    // Register the branch result and the link write for the write-back stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_valid_o <= 1'b0;
            wr_en_o    <= 1'b0;
            next_pc_o  <= '0;
            wr_data_o  <= '0;
            force0_o   <= 1'b0;
        end else begin
            br_valid_o <= is_branch;
            wr_en_o    <= is_branch;
            next_pc_o  <= is_branch ? target : '0;
            wr_data_o  <= is_branch ? link_word : '0;
            force0_o   <= is_branch && (dst_i != '0);
        end
    end

    // The destination is always register 0, whatever the encoding said.
    assign wr_addr_o = '0;

    // A younger read of register 0 must take the link word in flight.
    always_comb fwd_hit_o = wr_en_o && rd_valid_i && (rd_addr_i == '0);
endmodule

// File: rtl/lnk_branch_unit_chk.sv
// Property checker for lnk_branch_unit, attached by bind below.
// Assumes the default parameter relationships of the top module.
module lnk_branch_unit_chk #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 16,
    parameter int RA_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [PC_W-1:0]   pc_i,
    input logic              rd_valid_i,
    input logic [RA_W-1:0]   rd_addr_i,
    input logic              br_valid_o,
    input logic              wr_en_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              force0_o,
    input logic              fwd_hit_o
);
    p_wr_with_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_o == wr_en_o);

    p_branch_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd1 || op_i == 2'd2) |=> br_valid_o);

    p_quiet_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd0 || op_i == 2'd3) |=> !br_valid_o);

    p_return_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd1 || op_i == 2'd2) |=>
            wr_data_o[PC_W-1:0] == PC_W'($past(pc_i) + PC_W'(1)));

    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_data_o[DATA_W-3:PC_W] == '0);

    p_force_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force0_o |-> wr_en_o);

    p_fwd_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit_o |-> (wr_en_o && rd_valid_i && rd_addr_i == '0));
endmodule

bind lnk_branch_unit lnk_branch_unit_chk #(
    .DATA_W(DATA_W), .PC_W(PC_W), .RA_W(RA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .pc_i       (pc_i),
    .rd_valid_i (rd_valid_i),
    .rd_addr_i  (rd_addr_i),
    .br_valid_o (br_valid_o),
    .wr_en_o    (wr_en_o),
    .wr_data_o  (wr_data_o),
    .force0_o   (force0_o),
    .fwd_hit_o  (fwd_hit_o)
);

// File: tb/lnk_branch_unit_bench.sv
`timescale 1ns/1ps
module lnk_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic        tab_abs_i = 1'b0;
    logic        link_rel_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [31:0] opnd_i = '0;
    logic [31:0] dval_i = '0;
    logic [8:0]  s_imm_i = '0;
    logic [22:0] aug_val_i = '0;
    logic        z_i = 1'b0;
    logic        c_i = 1'b0;
    logic [8:0]  dst_i = '0;
    logic        rd_valid_i = 1'b0;
    logic [8:0]  rd_addr_i = '0;
    logic        br_valid_o;
    logic [15:0] next_pc_o;
    logic        wr_en_o;
    logic [8:0]  wr_addr_o;
    logic [31:0] wr_data_o;
    logic        force0_o;
    logic        fwd_hit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lnk_branch_unit u_lnk_branch_unit (.*);

    typedef struct packed {
        logic [1:0]  op;
        logic        abs_m;
        logic        rel;
        logic [15:0] pc;
        logic [31:0] opnd;
        logic [31:0] dval;
        logic [8:0]  s;
        logic        z;
        logic        c;
        logic [8:0]  dst;
        logic [15:0] exp_pc;
        logic [31:0] exp_word;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b0, 16'h0100, 32'h0000_0234, 32'h0, 9'h000, 1'b1, 1'b0, 9'd5, 16'h0234, 32'h8000_0101},
        '{2'd1, 1'b0, 1'b1, 16'h0100, 32'h0000_0010, 32'h0, 9'h000, 1'b0, 1'b1, 9'd5, 16'h0110, 32'h4000_0101},
        '{2'd2, 1'b0, 1'b0, 16'h0200, 32'h0, 32'h0000_0040, 9'h003, 1'b1, 1'b1, 9'd5, 16'h0243, 32'hC000_0201},
        '{2'd2, 1'b1, 1'b0, 16'h0200, 32'h0, 32'h0000_1000, 9'h003, 1'b0, 1'b0, 9'd5, 16'h100C, 32'h0000_0201},
        '{2'd2, 1'b0, 1'b0, 16'hFFFF, 32'h0, 32'h0, 9'h1FF, 1'b0, 1'b1, 9'd5, 16'h01FE, 32'h4000_0000},
        '{2'd1, 1'b0, 1'b0, 16'h7FFE, 32'h0000_ABCD, 32'h0, 9'h000, 1'b1, 1'b1, 9'd5, 16'hABCD, 32'hC000_7FFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one instruction at a falling edge; the result is registered at
    // the next rising edge and sampled after the following falling edge.
    task automatic issue(input logic [1:0] op, input logic abs_m, input logic rel,
                         input logic [15:0] pc, input logic [31:0] opnd,
                         input logic [31:0] dval, input logic [8:0] s,
                         input logic z, input logic c, input logic [8:0] dst,
                         input logic [22:0] aug);
        @(negedge clk);
        op_i = op; tab_abs_i = abs_m; link_rel_i = rel; pc_i = pc;
        opnd_i = opnd; dval_i = dval; s_imm_i = s; z_i = z; c_i = c;
        dst_i = dst; aug_val_i = aug;
        @(negedge clk);
        op_i = 2'd0;
        #0.5;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 reset br_valid", 64'(br_valid_o), 64'd0);
        chk("R10 reset wr_en", 64'(wr_en_o), 64'd0);
        chk("R10 reset data", 64'(wr_data_o), 64'd0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R5 R8 R9 R11-style wrap covered by R1/R4.
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].abs_m, VECS[i].rel, VECS[i].pc, VECS[i].opnd,
                  VECS[i].dval, VECS[i].s, VECS[i].z, VECS[i].c, VECS[i].dst, 23'd0);
            chk($sformatf("R3/R4/R5 target vec%0d", i), 64'(next_pc_o), 64'(VECS[i].exp_pc));
            chk($sformatf("R1 link word vec%0d", i), 64'(wr_data_o), 64'(VECS[i].exp_word));
            chk($sformatf("R2 write vec%0d", i), 64'({br_valid_o, wr_en_o, wr_addr_o}), 64'({1'b1, 1'b1, 9'd0}));
            chk($sformatf("R8 force vec%0d", i), 64'(force0_o), 64'd1);
            rd_valid_i = 1'b1; rd_addr_i = 9'd0; #0.5;
            chk($sformatf("R9 fwd hit vec%0d", i), 64'(fwd_hit_o), 64'd1);
            rd_addr_i = 9'd3; #0.5;
            chk($sformatf("R9 fwd other vec%0d", i), 64'(fwd_hit_o), 64'd0);
            rd_valid_i = 1'b0; rd_addr_i = 9'd0;
        end

        // R7/R10: prefix alone makes no branch.
        issue(2'd3, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0, 9'h0, 1'b0, 1'b0, 9'd0, 23'd1);
        chk("R10 prefix no branch", 64'({br_valid_o, wr_en_o}), 64'd0);
        // Bubble keeps the prefix held (R7).
        issue(2'd0, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0, 9'h0, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R10 bubble no branch", 64'({br_valid_o, wr_en_o}), 64'd0);
        // R6: offset = {1, 9'h002} = 0x202.
        issue(2'd2, 1'b0, 1'b0, 16'h0000, 32'h0, 32'h0, 9'h002, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R6 prefixed table target", 64'(next_pc_o), 64'h0202);
        chk("R8 no force for dst 0", 64'(force0_o), 64'd0);
        // R7: prefix consumed once.
        issue(2'd2, 1'b0, 1'b0, 16'h0000, 32'h0, 32'h0, 9'h002, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R7 prefix cleared", 64'(next_pc_o), 64'h0002);
        // R7: link consumes the prefix but is not altered by it.
        issue(2'd3, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0, 9'h0, 1'b0, 1'b0, 9'd0, 23'd3);
        issue(2'd1, 1'b0, 1'b0, 16'h0000, 32'h0000_0050, 32'h0, 9'h000, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R7 link unaffected by prefix", 64'(next_pc_o), 64'h0050);
        issue(2'd2, 1'b0, 1'b0, 16'h0000, 32'h0, 32'h0, 9'h002, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R7 prefix consumed by link", 64'(next_pc_o), 64'h0002);
        // R6 with R5: absolute mode scales the prefixed offset: 0x201<<2.
        issue(2'd3, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0, 9'h0, 1'b0, 1'b0, 9'd0, 23'd1);
        issue(2'd2, 1'b1, 1'b0, 16'h0000, 32'h0, 32'h0, 9'h001, 1'b0, 1'b0, 9'd0, 23'd0);
        chk("R6 prefixed absolute target", 64'(next_pc_o), 64'h0804);

        // R9: forward check in the same cycle a new branch is presented.
        issue(2'd1, 1'b0, 1'b0, 16'h0010, 32'h0000_0300, 32'h0, 9'h0, 1'b1, 1'b0, 9'd2, 23'd0);
        op_i = 2'd1; opnd_i = 32'h0000_0400; pc_i = 16'h0020; z_i = 1'b0;
        rd_valid_i = 1'b1; rd_addr_i = 9'd0; #0.5;
        chk("R9 fwd hit while new branch presented", 64'(fwd_hit_o), 64'd1);
        chk("R9 in-flight word is older", 64'(wr_data_o), 64'h8000_0011);
        @(negedge clk); op_i = 2'd0; rd_valid_i = 1'b0; #0.5;
        chk("R3 newer branch one edge later", 64'(next_pc_o), 64'h0400);
        chk("R1 newer link word", 64'(wr_data_o), 64'h0000_0021);
        issue(2'd0, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0, 9'h0, 1'b0, 1'b0, 9'd0, 23'd0);
        rd_valid_i = 1'b1; #0.5;
        chk("R9 no hit without write", 64'(fwd_hit_o), 64'd0);
        rd_valid_i = 1'b0;

        // R10: reset clears a pending result.
        issue(2'd1, 1'b0, 1'b0, 16'h0001, 32'h0000_0777, 32'h0, 9'h0, 1'b1, 1'b1, 9'd1, 23'd0);
        rst_n = 1'b0;
        @(negedge clk); #0.5;
        chk("R10 reset clears branch", 64'({br_valid_o, wr_en_o, force0_o}), 64'd0);
        chk("R10 reset clears data", 64'(wr_data_o), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule